// File: doc/BRIEF.md
# Register File with Special-Register Access

This block is the integer register file of a small 32-bit RISC core. It holds 32 general registers of 32 bits, with two combinational read ports and one write port for ordinary instructions. Register 0 is tied to zero. A read of a register that is being written in the same cycle returns the value being written.

Beside the general registers, the block keeps two special values. The first is the address of the instruction now executing, which the fetch stage supplies. The second is a delay-return register. A separate special-register path reads and writes these values through a 16-bit selector. The executing-instruction address can be read through this path, but nothing can write it there.

When the pipeline reports a hardware exception, the block computes the return address as the faulting address plus 4. It writes that value into general register 17. If the faulting instruction sat in a branch delay slot, it writes the value into the delay-return register instead.

Top module: `rfx_regfile`

## Requirements
- R1: After synchronous reset, all 32 general registers, the executing-address register and the delay-return register read 0x00000000.
- R2: A write with `gw_en` high stores `gw_data` into register `gw_idx` at the clock edge. Both read ports return it combinationally from then on.
- R3: Register 0 always reads zero on both ports. A write aimed at it is discarded, even in the cycle of the write.
- R4: A read of a nonzero register that is being written in the same cycle returns the new value, on either port. During an exception capture, this applies to register 17 with the return address.
- R5: When `pc_load` is high, the executing-address register takes `pc_in` at the clock edge. A special read with selector 0x0000 returns the register's current value, which is the address of the instruction doing the read.
- R6: A special write to selector 0x0000 leaves the executing-address register unchanged.
- R7: When `exc_valid` is high and `exc_dslot` is low, register 17 takes `exc_addr + 4`, modulo 2^32, at the clock edge.
- R8: When `exc_valid` and `exc_dslot` are both high, register 17 keeps its value and the delay-return register takes `exc_addr + 4`.
- R9: A non-delay-slot exception capture overrides an ordinary write to register 17 in the same cycle. An ordinary write to any other register in that cycle still takes effect.
- R10: A special read with any selector other than 0x0000 and 0x000C returns zero.
- R11: Selector 0x000C reads the delay-return register. A special write to 0x000C loads it, but a delay-slot capture in the same cycle takes priority. Special reads show stored values only, with no same-cycle bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_idx | input | 5 | Read port A register index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 5 | Read port B register index |
| rb_data | output | 32 | Read port B data |
| gw_en | input | 1 | General write enable |
| gw_idx | input | 5 | General write register index |
| gw_data | input | 32 | General write data |
| pc_load | input | 1 | Load the executing-address register |
| pc_in | input | 32 | Executing-instruction address from fetch |
| sp_rd_sel | input | 16 | Special read selector |
| sp_rd_data | output | 32 | Special read data |
| sp_wr_en | input | 1 | Special write enable |
| sp_wr_sel | input | 16 | Special write selector |
| sp_wr_data | input | 32 | Special write data |
| exc_valid | input | 1 | Exception capture strobe |
| exc_dslot | input | 1 | Faulting instruction was in a delay slot |
| exc_addr | input | 32 | Faulting instruction address |

## Verification
The assertions assume that reset is held for at least one clock edge before any check counts. They also assume that every control input carries a defined 0 or 1 on each edge, because the stability checks on register 17 and on the executing address reason from the enables alone. The bench drives every input away from the clock edge, from known values, starting in the reset cycle. During random stimulus it raises the exception strobe about one cycle in eight, so both capture kinds collide with ordinary writes to register 17 and with special writes to 0x000C.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int AW     = $clog2(NREG);
    localparam int SELW   = 16;
    localparam int NRP    = 2;
    localparam int CAP_IDX = 17;
    localparam int STEP   = 4;

    localparam logic [SELW-1:0] SEL_PC   = 16'h0000;
    localparam logic [SELW-1:0] SEL_DRET = 16'h000C;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [AW-1:0]   ridx_t;

    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t data;
    } gwr_t;

    typedef struct packed {
        logic  en;
        word_t data;
    } cap_t;

    typedef enum logic [1:0] {
        SPK_PC   = 2'd0,
        SPK_DRET = 2'd1,
        SPK_NONE = 2'd2
    } spr_kind_e;

    function automatic spr_kind_e sel_decode(input logic [SELW-1:0] s);
        if (s == SEL_PC)   return SPK_PC;
        if (s == SEL_DRET) return SPK_DRET;
        return SPK_NONE;
    endfunction

    function automatic word_t ret_addr(input word_t a);
        return a + word_t'(STEP);
    endfunction

endpackage

// File: rtl/rfx_gpr_bank.sv
module rfx_gpr_bank
    import rfx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  gwr_t  wr_i,
    input  cap_t  cap_i,
    output word_t regs_o [NREG]
);

    localparam ridx_t CAP_R = ridx_t'(CAP_IDX);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam ridx_t MY_IDX = ridx_t'(i);
        if (i == 0) begin : g_zero
            assign regs_o[i] = '0;
        end else if (i == CAP_IDX) begin : g_cap
            always_ff @(posedge clk) begin
                if (rst)
                    regs_o[i] <= '0;
                else if (cap_i.en)
                    regs_o[i] <= cap_i.data;
                else if (wr_i.en && wr_i.idx == MY_IDX)
                    regs_o[i] <= wr_i.data;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    regs_o[i] <= '0;
                else if (wr_i.en && wr_i.idx == MY_IDX)
                    regs_o[i] <= wr_i.data;
            end
        end
    end

    // R7: capture lands in register 17 one edge later
    a_r7_capture_lands: assert property (@(posedge clk) disable iff (rst)
        cap_i.en |=> regs_o[CAP_IDX] == $past(cap_i.data));

    // R8: register 17 holds without a capture or a write to it
    a_r8_r17_holds: assert property (@(posedge clk) disable iff (rst)
        (!cap_i.en && !(wr_i.en && wr_i.idx == CAP_R)) |=> $stable(regs_o[CAP_IDX]));

endmodule

// File: rtl/rfx_read_port.sv
module rfx_read_port
    import rfx_pkg::*;
(
    input  ridx_t idx_i,
    input  word_t regs_i [NREG],
    input  gwr_t  wr_i,
    input  cap_t  cap_i,
    output word_t data_o
);

    localparam ridx_t CAP_R = ridx_t'(CAP_IDX);

    always_comb begin
        if (idx_i == '0)
            data_o = '0;
        else if (cap_i.en && idx_i == CAP_R)
            data_o = cap_i.data;
        else if (wr_i.en && wr_i.idx == idx_i)
            data_o = wr_i.data;
        else
            data_o = regs_i[idx_i];
    end

endmodule

// File: rtl/rfx_special_unit.sv
module rfx_special_unit
    import rfx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pc_load_i,
    input  word_t           pc_in_i,
    input  logic [SELW-1:0] rd_sel_i,
    output word_t           rd_data_o,
    input  logic            wr_en_i,
    input  logic [SELW-1:0] wr_sel_i,
    input  word_t           wr_data_i,
    input  cap_t            dcap_i
);

    word_t     pc_q;
    word_t     dret_q;
    spr_kind_e rd_kind;
    spr_kind_e wr_kind;

    assign rd_kind = sel_decode(rd_sel_i);
    assign wr_kind = sel_decode(wr_sel_i);

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (pc_load_i)
            pc_q <= pc_in_i;
    end

    always_ff @(posedge clk) begin
        if (rst)
            dret_q <= '0;
        else if (dcap_i.en)
            dret_q <= dcap_i.data;
        else if (wr_en_i && wr_kind == SPK_DRET)
            dret_q <= wr_data_i;
    end

    always_comb begin
        unique case (rd_kind)
            SPK_PC:   rd_data_o = pc_q;
            SPK_DRET: rd_data_o = dret_q;
            default:  rd_data_o = '0;
        endcase
    end

    // R6: no special write moves the executing address
    a_r6_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !pc_load_i |=> $stable(pc_q));

    // R11: a delay-slot capture always wins the delay-return register
    a_r11_dcap_wins: assert property (@(posedge clk) disable iff (rst)
        dcap_i.en |=> dret_q == $past(dcap_i.data));

endmodule

// File: rtl/rfx_regfile.sv
module rfx_regfile
    import rfx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  ra_idx,
    output logic [31:0] ra_data,
    input  logic [4:0]  rb_idx,
    output logic [31:0] rb_data,
    input  logic        gw_en,
    input  logic [4:0]  gw_idx,
    input  logic [31:0] gw_data,
    input  logic        pc_load,
    input  logic [31:0] pc_in,
    input  logic [15:0] sp_rd_sel,
    output logic [31:0] sp_rd_data,
    input  logic        sp_wr_en,
    input  logic [15:0] sp_wr_sel,
    input  logic [31:0] sp_wr_data,
    input  logic        exc_valid,
    input  logic        exc_dslot,
    input  logic [31:0] exc_addr
);

    gwr_t  wr;
    cap_t  gcap;
    cap_t  dcap;
    word_t ret;
    word_t regs [NREG];
    ridx_t rd_idx [NRP];
    word_t rd_data [NRP];

    assign ret       = ret_addr(exc_addr);
    assign wr.en     = gw_en;
    assign wr.idx    = gw_idx;
    assign wr.data   = gw_data;
    assign gcap.en   = exc_valid && !exc_dslot;
    assign gcap.data = ret;
    assign dcap.en   = exc_valid && exc_dslot;
    assign dcap.data = ret;

    assign rd_idx[0] = ra_idx;
    assign rd_idx[1] = rb_idx;
    assign ra_data   = rd_data[0];
    assign rb_data   = rd_data[1];

    rfx_gpr_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr),
        .cap_i  (gcap),
        .regs_o (regs)
    );

    for (genvar p = 0; p < NRP; p++) begin : g_rport
        rfx_read_port u_rport (
            .idx_i  (rd_idx[p]),
            .regs_i (regs),
            .wr_i   (wr),
            .cap_i  (gcap),
            .data_o (rd_data[p])
        );
    end

    rfx_special_unit u_spec (
        .clk       (clk),
        .rst       (rst),
        .pc_load_i (pc_load),
        .pc_in_i   (pc_in),
        .rd_sel_i  (sp_rd_sel),
        .rd_data_o (sp_rd_data),
        .wr_en_i   (sp_wr_en),
        .wr_sel_i  (sp_wr_sel),
        .wr_data_i (sp_wr_data),
        .dcap_i    (dcap)
    );

    // R3: port A never returns nonzero for index 0
    a_r3_zero_reads: assert property (@(posedge clk) disable iff (rst)
        ra_idx == '0 |-> ra_data == '0);

    // R4: same-cycle write is visible on port B
    a_r4_bypass: assert property (@(posedge clk) disable iff (rst)
        (gw_en && gw_idx != '0 && rb_idx == gw_idx &&
         !(gcap.en && gw_idx == ridx_t'(CAP_IDX))) |-> rb_data == gw_data);

endmodule

// File: tb/rfx_regfile_tb.sv
module rfx_regfile_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  ra_idx = '0, rb_idx = '0, gw_idx = '0;
    logic [31:0] ra_data, rb_data, sp_rd_data;
    logic        gw_en = 1'b0, pc_load = 1'b0, sp_wr_en = 1'b0;
    logic        exc_valid = 1'b0, exc_dslot = 1'b0;
    logic [31:0] gw_data = '0, pc_in = '0, sp_wr_data = '0, exc_addr = '0;
    logic [15:0] sp_rd_sel = '0, sp_wr_sel = '0;

    logic [31:0] m_reg [32];
    logic [31:0] m_pc, m_dret;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rfx_regfile u_dut (.*);

    function automatic logic [31:0] exp_rd(input logic [4:0] a);
        if (a == 0) return 32'h0;
        if (exc_valid && !exc_dslot && a == 5'd17) return exc_addr + 32'd4;
        if (gw_en && gw_idx == a) return gw_data;
        return m_reg[a];
    endfunction

    function automatic logic [31:0] exp_sp(input logic [15:0] s);
        if (s == 16'h0000) return m_pc;
        if (s == 16'h000C) return m_dret;
        return 32'h0;
    endfunction

    function automatic string rd_tag(input logic [4:0] a);
        if (a == 0) return "R3";
        if ((gw_en && gw_idx == a) || (exc_valid && a == 5'd17)) return "R4";
        return "R2";
    endfunction

    function automatic string sp_tag(input logic [15:0] s);
        if (s == 16'h0000) return "R5";
        if (s == 16'h000C) return "R11";
        return "R10";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        chk((tag == "") ? rd_tag(ra_idx) : tag, ra_data, exp_rd(ra_idx));
        chk((tag == "") ? rd_tag(rb_idx) : tag, rb_data, exp_rd(rb_idx));
        chk((tag == "") ? sp_tag(sp_rd_sel) : tag, sp_rd_data, exp_sp(sp_rd_sel));
    endtask

    task automatic idle();
        gw_en = 0; pc_load = 0; sp_wr_en = 0; exc_valid = 0; exc_dslot = 0;
    endtask

    // inputs are set just after a falling edge; check, clock, update model
    task automatic step(input string tag);
        #1;
        check_outs(tag);
        @(posedge clk);
        if (pc_load) m_pc = pc_in;
        if (gw_en && gw_idx != 0 && !(exc_valid && !exc_dslot && gw_idx == 5'd17))
            m_reg[gw_idx] = gw_data;
        if (exc_valid && !exc_dslot) m_reg[17] = exc_addr + 32'd4;
        if (exc_valid && exc_dslot) m_dret = exc_addr + 32'd4;
        else if (sp_wr_en && sp_wr_sel == 16'h000C) m_dret = sp_wr_data;
        @(negedge clk);
        idle();
    endtask

    task automatic look(input string tag, input logic [4:0] a, input logic [4:0] b,
                        input logic [15:0] s);
        ra_idx = a; rb_idx = b; sp_rd_sel = s;
        #1;
        check_outs(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
        m_pc = 0; m_dret = 0;
        // drive garbage writes during reset; they must not stick
        gw_en = 1; gw_idx = 5'd3; gw_data = 32'hBAD0BAD0; pc_load = 1; pc_in = 32'h44;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        idle();

        // R1 reset values
        for (int i = 0; i < 32; i++) look("R1", 5'(i), 5'(31 - i), 16'h0000);
        look("R1", 5'd0, 5'd0, 16'h000C);

        // R2 write and read back
        gw_en = 1; gw_idx = 5'd5; gw_data = 32'hA5A5_0005; step("R4");
        look("R2", 5'd5, 5'd5, 16'h0001);

        // R3 writes to register 0 are discarded, even in the write cycle
        gw_en = 1; gw_idx = 5'd0; gw_data = 32'hFFFF_FFFF;
        ra_idx = 0; rb_idx = 0; step("R3");
        look("R3", 5'd0, 5'd0, 16'h0000);

        // R4 bypass on both ports
        gw_en = 1; gw_idx = 5'd9; gw_data = 32'h1234_5678;
        ra_idx = 9; rb_idx = 9; step("R4");

        // R5 executing address load then read
        pc_load = 1; pc_in = 32'h0000_1000; step("R5");
        look("R5", 5'd1, 5'd2, 16'h0000);

        // R6 special write to the address selector ignored
        sp_wr_en = 1; sp_wr_sel = 16'h0000; sp_wr_data = 32'hDEAD_BEEF; step("R6");
        look("R6", 5'd1, 5'd2, 16'h0000);
        chk("R6", sp_rd_data, 32'h0000_1000);

        // R7 capture, including wraparound
        exc_valid = 1; exc_addr = 32'h0000_0200; ra_idx = 17; step("R4");
        look("R7", 5'd17, 5'd17, 16'h000C);
        chk("R7", ra_data, 32'h0000_0204);
        exc_valid = 1; exc_addr = 32'hFFFF_FFFC; step("R4");
        look("R7", 5'd17, 5'd0, 16'h0000);
        chk("R7", ra_data, 32'h0);

        // R8 delay-slot capture leaves register 17, loads delay-return
        gw_en = 1; gw_idx = 5'd17; gw_data = 32'h0000_0777; step("R2");
        exc_valid = 1; exc_dslot = 1; exc_addr = 32'h0000_0300; step("R8");
        look("R8", 5'd17, 5'd17, 16'h000C);
        chk("R8", ra_data, 32'h0000_0777);
        chk("R8", sp_rd_data, 32'h0000_0304);

        // R9 capture beats ordinary write to 17
        exc_valid = 1; exc_addr = 32'h0000_0400; gw_en = 1; gw_idx = 5'd17;
        gw_data = 32'h5555_5555; rb_idx = 17; step("R9");
        look("R9", 5'd17, 5'd17, 16'h0000);
        chk("R9", ra_data, 32'h0000_0404);
        // R9 other register still written alongside a capture
        exc_valid = 1; exc_addr = 32'h0000_0500; gw_en = 1; gw_idx = 5'd9;
        gw_data = 32'h0909_0909; step("R9");
        look("R9", 5'd9, 5'd17, 16'h0000);
        chk("R9", ra_data, 32'h0909_0909);

        // R10 unimplemented selectors
        look("R10", 5'd0, 5'd0, 16'h0001);
        chk("R10", sp_rd_data, 32'h0);
        look("R10", 5'd0, 5'd0, 16'hFFFF);

        // R11 special write, then collision with a delay-slot capture
        sp_wr_en = 1; sp_wr_sel = 16'h000C; sp_wr_data = 32'hCAFE_0001; step("R11");
        look("R11", 5'd0, 5'd0, 16'h000C);
        chk("R11", sp_rd_data, 32'hCAFE_0001);
        sp_wr_en = 1; sp_wr_sel = 16'h000C; sp_wr_data = 32'hCAFE_0002;
        exc_valid = 1; exc_dslot = 1; exc_addr = 32'h0000_0600; step("R11");
        look("R11", 5'd0, 5'd0, 16'h000C);
        chk("R11", sp_rd_data, 32'h0000_0604);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int k;
            ra_idx = 5'($urandom);
            rb_idx = ($urandom % 4 == 0) ? 5'd17 : 5'($urandom);
            gw_en = $urandom % 3 != 0;
            k = $urandom % 4;
            gw_idx = (k == 0) ? 5'd0 : (k == 1) ? 5'd17 : (k == 2) ? ra_idx : 5'($urandom);
            gw_data = $urandom;
            pc_load = $urandom % 2;
            pc_in = $urandom;
            k = $urandom % 3;
            sp_rd_sel = (k == 0) ? 16'h0000 : (k == 1) ? 16'h000C : 16'($urandom);
            sp_wr_en = $urandom % 3 == 0;
            k = $urandom % 3;
            sp_wr_sel = (k == 0) ? 16'h0000 : (k == 1) ? 16'h000C : 16'($urandom);
            sp_wr_data = $urandom;
            exc_valid = $urandom % 8 == 0;
            exc_dslot = $urandom % 2;
            exc_addr = $urandom;
            step("");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule